// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps a multiplexed-address DRAM alive. After reset it holds the strobes idle for a programmable power-up pause. It then runs a burst of eight refresh cycles with no handshake, and only after that raises `init_done`, which lets the access controller start work. From then on an interval timer adds one owed refresh every `REFI_CYC` clocks. While any refresh is owed the sequencer raises `ref_req`. Each time the access controller answers with `ref_gnt`, the sequencer runs one column-before-row refresh cycle on `ras_n`/`cas_n`.

Owed refreshes build up in a small saturating counter, so a controller that holds off the grant for several intervals is repaid with a back-to-back run of cycles once it grants. The block also watches row strobe activity, both its own and the activity reported on `host_row_act`. If the row strobe stays quiet for `IDLE_CYC` clocks, `init_done` drops and a new eight-cycle wake-up burst runs before access resumes. Row-address refresh and the data path are handled elsewhere. During a refresh cycle the address bus and write enable are not driven by this block. All timing parameters are counted in clocks, so a simulation can use short values.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n` and `cas_n` are high, `init_done` and `ref_req` are low, and `ref_pending` is 0.
- R2: After reset is released, no strobe goes low for at least `PAUSE_CYC` clock cycles, and `init_done` stays low.
- R3: After the pause, exactly `WAKE_N` refresh cycles run without any grant. `init_done` rises after the last of them and not before. `ref_req` stays low whenever `init_done` is low.
- R4: In every refresh cycle `cas_n` goes low `CSR_CYC` cycles before `ras_n` goes low. `cas_n` stays low for as long as `ras_n` is low, and both strobes return high on the same edge.
- R5: `ras_n` stays low for exactly `RAS_LOW_CYC` cycles per refresh. Both strobes stay high for at least `PRE_CYC` cycles before `cas_n` falls again.
- R6: Once `init_done` is high, one refresh is owed every `REFI_CYC` cycles. With a standing grant, exactly one refresh cycle runs per interval.
- R7: After `init_done`, a refresh cycle starts only on a cycle where `ref_gnt` is high. Without a grant, `ref_req` stays high and no strobe moves.
- R8: `ref_pending` counts owed refreshes and saturates at `MAX_DEBT`. An interval that ends while the count is full is dropped. The count changes by at most one per cycle.
- R9: When granted, owed refreshes are issued back to back, each completed cycle lowering `ref_pending` by one. `ref_req` falls once the count is zero and no cycle is running.
- R10: If neither this block's strobes nor `host_row_act` show activity for `IDLE_CYC` cycles, `init_done` falls, a new burst of `WAKE_N` refresh cycles runs without a grant, and `init_done` rises again afterwards.
- R11: A pulse on `host_row_act` restarts the idle time, so periodic host activity keeps `init_done` high even while refresh is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_row_act | input | 1 | High in a cycle where the access controller has the row strobe active |
| ref_gnt | input | 1 | Access controller hands the strobes to the sequencer |
| ref_req | output | 1 | At least one refresh owed or a refresh cycle running |
| init_done | output | 1 | Device initialized; host accesses allowed |
| ref_pending | output | $clog2(MAX_DEBT+1) | Number of owed refreshes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
The assertions check the strobe shape on every cycle. They cover column-before-row ordering, the exact row-low width, the minimum precharge, and both strobes rising together. They also check that `ref_req` is gated by `init_done`, that no refresh starts without a grant, and that `ref_pending` stays within its cap and moves by at most one per cycle. Only the bench scenarios can show the counted behaviours over long stretches: the length of the pause, the exact number of wake-up cycles, one refresh per interval under a standing grant, repayment of exactly the saturated debt, and the idle timeout being restarted by host activity and firing when that activity stops.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE,
    MODE_WAKE,
    MODE_RUN
  } seq_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CSETUP,
    PH_RLOW,
    PH_PRECH
  } cbr_phase_e;

endpackage

// File: rtl/cbr_cycle_gen.sv
module cbr_cycle_gen
  import dram_refresh_pkg::*;
#(
  parameter int CSR_CYC     = 1,
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic cyc_done,
  output logic ras_n,
  output logic cas_n
);

  localparam int MAXLEN = (CSR_CYC > RAS_LOW_CYC) ?
                          ((CSR_CYC > PRE_CYC) ? CSR_CYC : PRE_CYC) :
                          ((RAS_LOW_CYC > PRE_CYC) ? RAS_LOW_CYC : PRE_CYC);
  localparam int CW = $clog2(MAXLEN + 1);

  cbr_phase_e      phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    last    = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_CSETUP;
          cnt_d   = '0;
        end
      end
      PH_CSETUP: begin
        if (cnt_q == CW'(CSR_CYC - 1)) begin
          phase_d = PH_RLOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_RLOW: begin
        if (cnt_q == CW'(RAS_LOW_CYC - 1)) begin
          phase_d = PH_PRECH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (cnt_q == CW'(PRE_CYC - 1)) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          last    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign cyc_done = last;
  assign ras_n    = (phase_q != PH_RLOW);
  assign cas_n    = !((phase_q == PH_CSETUP) || (phase_q == PH_RLOW));

endmodule

// File: rtl/refresh_debt_tracker.sv
module refresh_debt_tracker #(
  parameter int REFI_CYC = 780,
  parameter int MAX_DEBT = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          consume,
  output logic [DW-1:0] debt
);

  localparam int TW = $clog2(REFI_CYC + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [DW-1:0] debt_q, debt_d;
  logic          tick;

  assign tick = en && (tmr_q == TW'(REFI_CYC - 1));

  always_comb begin
    if (!en || tick) tmr_d = '0;
    else             tmr_d = tmr_q + 1'b1;
  end

  always_comb begin
    debt_d = debt_q;
    if (!en) begin
      debt_d = '0;
    end else if (tick && !consume) begin
      if (debt_q != DW'(MAX_DEBT)) debt_d = debt_q + 1'b1;
    end else if (consume && !tick) begin
      if (debt_q != '0) debt_d = debt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      debt_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      debt_q <= debt_d;
    end
  end

  assign debt = debt_q;

endmodule

// File: rtl/idle_monitor.sv
module idle_monitor #(
  parameter int IDLE_CYC = 820000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic activity,
  output logic expired
);

  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [IW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == IW'(IDLE_CYC - 1));

  always_comb begin
    if (!arm || activity) cnt_d = '0;
    else if (!at_limit)   cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = arm && !activity && at_limit;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC   = 25000,
  parameter int REFI_CYC    = 780,
  parameter int CSR_CYC     = 1,
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2,
  parameter int IDLE_CYC    = 820000,
  parameter int WAKE_N      = 8,
  parameter int MAX_DEBT    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_row_act,
  input  logic                          ref_gnt,
  output logic                          ref_req,
  output logic                          init_done,
  output logic [$clog2(MAX_DEBT+1)-1:0] ref_pending,
  output logic                          ras_n,
  output logic                          cas_n
);

  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WAKE_N + 1);
  localparam int DW = $clog2(MAX_DEBT + 1);

  seq_mode_e     mode_q, mode_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [WW-1:0] wake_q, wake_d;

  logic          start, busy, cyc_done, consume, idle_exp;
  logic [DW-1:0] debt;

  assign start = !busy &&
                 ((mode_q == MODE_WAKE) ||
                  ((mode_q == MODE_RUN) && (debt != '0) && ref_gnt));
  assign consume = cyc_done && (mode_q == MODE_RUN);

  always_comb begin
    mode_d  = mode_q;
    pause_d = pause_q;
    wake_d  = wake_q;
    unique case (mode_q)
      MODE_PAUSE: begin
        if (pause_q == PW'(PAUSE_CYC - 1)) begin
          mode_d  = MODE_WAKE;
          pause_d = '0;
          wake_d  = '0;
        end else begin
          pause_d = pause_q + 1'b1;
        end
      end
      MODE_WAKE: begin
        if (cyc_done) begin
          if (wake_q == WW'(WAKE_N - 1)) begin
            mode_d = MODE_RUN;
            wake_d = '0;
          end else begin
            wake_d = wake_q + 1'b1;
          end
        end
      end
      default: begin
        if (idle_exp) begin
          mode_d = MODE_WAKE;
          wake_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      pause_q <= pause_d;
      wake_q  <= wake_d;
    end
  end

  cbr_cycle_gen #(
    .CSR_CYC    (CSR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRE_CYC    (PRE_CYC)
  ) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .cyc_done(cyc_done),
    .ras_n   (ras_n),
    .cas_n   (cas_n)
  );

  refresh_debt_tracker #(
    .REFI_CYC(REFI_CYC),
    .MAX_DEBT(MAX_DEBT)
  ) u_debt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (mode_q != MODE_PAUSE),
    .consume(consume),
    .debt   (debt)
  );

  idle_monitor #(
    .IDLE_CYC(IDLE_CYC)
  ) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (mode_q == MODE_RUN),
    .activity(host_row_act || busy),
    .expired (idle_exp)
  );

  assign init_done   = (mode_q == MODE_RUN);
  assign ref_req     = (mode_q == MODE_RUN) && ((debt != '0) || busy);
  assign ref_pending = debt;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_LOW_CYC = 3,
  parameter int PRE_CYC     = 2,
  parameter int MAX_DEBT    = 8,
  localparam int DW = $clog2(MAX_DEBT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          init_done,
  input logic [DW-1:0] ref_pending,
  input logic          ras_n,
  input logic          cas_n
);

  localparam logic [31:0]   RL   = 32'(RAS_LOW_CYC);
  localparam logic [31:0]   PR   = 32'(PRE_CYC);
  localparam logic [DW-1:0] MAXD = DW'(MAX_DEBT);

  logic [31:0] low_run, high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      if (!ras_n) low_run <= (low_run == 32'hFFFF_FFFF) ? low_run : low_run + 1;
      else        low_run <= '0;
      if (ras_n && cas_n) high_run <= (high_run == 32'hFFFF_FFFF) ? high_run : high_run + 1;
      else                high_run <= '0;
    end
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));

  a_r4_cas_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  a_r4_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));

  a_r5_ras_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run == RL));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (high_run >= PR));

  a_r3_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);

  a_r7_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $fell(cas_n)) |-> $past(ref_gnt));

  a_r8_pending_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending <= MAXD);

  a_r8_pending_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending == $past(ref_pending)) ||
    (ref_pending == $past(ref_pending) + 1'b1) ||
    ($past(ref_pending) == ref_pending + 1'b1));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_LOW_CYC(RAS_LOW_CYC),
  .PRE_CYC    (PRE_CYC),
  .MAX_DEBT   (MAX_DEBT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_gnt    (ref_gnt),
  .ref_req    (ref_req),
  .init_done  (init_done),
  .ref_pending(ref_pending),
  .ras_n      (ras_n),
  .cas_n      (cas_n)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

  localparam int PAUSE = 20;
  localparam int REFI  = 200;
  localparam int CSR   = 2;
  localparam int RLOW  = 4;
  localparam int PRE   = 3;
  localparam int IDLE  = 3000;
  localparam int WAKE  = 8;
  localparam int MAXD  = 8;
  localparam int DW    = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_row_act = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, init_done, ras_n, cas_n;
  logic [DW-1:0] ref_pending;

  int n_checks = 0;
  int n_fail   = 0;

  int ras_falls = 0;
  int ord_bad   = 0;
  int width_bad = 0;
  int pre_bad   = 0;
  int low_len   = 0;
  int high_len  = 0;
  logic prev_ras = 1'b1;
  logic prev_cas = 1'b1;

  always #10 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .REFI_CYC(REFI), .CSR_CYC(CSR), .RAS_LOW_CYC(RLOW),
    .PRE_CYC(PRE), .IDLE_CYC(IDLE), .WAKE_N(WAKE), .MAX_DEBT(MAXD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .host_row_act(host_row_act), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .init_done(init_done), .ref_pending(ref_pending),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  // strobe shape monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        ras_falls++;
        if (prev_cas) ord_bad++;
      end
      if (!prev_ras && ras_n && (low_len != RLOW)) width_bad++;
      if (prev_cas && !cas_n && (high_len < PRE)) pre_bad++;
      if (!ras_n && cas_n) ord_bad++;
      low_len  = !ras_n ? low_len + 1 : 0;
      high_len = (ras_n && cas_n) ? high_len + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    check(ras_n == 1'b1 && cas_n == 1'b1, "R1 strobes", {ras_n, cas_n}, 3);
    check(init_done == 1'b0, "R1 init_done", init_done, 0);
    check(ref_req == 1'b0, "R1 ref_req", ref_req, 0);
    check(ref_pending == '0, "R1 ref_pending", ref_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && !init_done && !ref_req, "R1 after release",
          {ras_n, cas_n, init_done, ref_req}, 12);
  endtask

  task automatic t_power_up();
    int n = 1;
    int base;
    int req_bad = 0;
    bit done_early = 0;
    while (cas_n && n < 1000) begin
      if (init_done) done_early = 1;
      @(negedge clk);
      n++;
    end
    check(n >= PAUSE && !done_early, "R2 pause length", n, PAUSE);
    base = ras_falls;
    n = 0;
    while (!init_done && n < 2000) begin
      if (ref_req) req_bad++;
      @(negedge clk);
      n++;
    end
    check(init_done == 1'b1, "R3 init_done rises", init_done, 1);
    check(ras_falls - base == WAKE, "R3 wake cycle count", ras_falls - base, WAKE);
    check(req_bad == 0, "R3 req low before done", req_bad, 0);
  endtask

  task automatic t_hold_without_grant();
    int n = 0;
    int base;
    ref_gnt = 1'b0;
    while (!ref_req && n < REFI + 5) begin
      @(negedge clk);
      n++;
    end
    check(ref_req == 1'b1, "R6 request after interval", ref_req, 1);
    check(ref_pending == 1, "R6 one owed", ref_pending, 1);
    base = ras_falls;
    cyc(REFI / 2);
    check(ras_falls == base, "R7 no cycle without grant", ras_falls - base, 0);
    check(ref_req == 1'b1, "R7 request held", ref_req, 1);
  endtask

  task automatic t_saturate_and_catchup();
    int n = 0;
    int base;
    while (ref_pending != MAXD && n < 12 * REFI) begin
      @(negedge clk);
      n++;
    end
    cyc(2 * REFI + 5);
    check(ref_pending == MAXD, "R8 saturated", ref_pending, MAXD);
    base = ras_falls;
    ref_gnt = 1'b1;
    n = 0;
    while (ref_req && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(ras_falls - base == MAXD, "R9 catch-up count", ras_falls - base, MAXD);
    check(n <= MAXD * (CSR + RLOW + PRE + 1) + 3, "R9 back to back", n,
          MAXD * (CSR + RLOW + PRE + 1) + 3);
    check(ref_pending == 0 && !ref_req, "R9 drained", ref_pending, 0);
  endtask

  task automatic t_steady_refresh();
    int n = 0;
    int base;
    ref_gnt = 1'b1;
    while (!ref_req && n < REFI + 5) begin
      @(negedge clk);
      n++;
    end
    base = ras_falls;
    cyc(5 * REFI - 1);
    check(ras_falls - base == 5, "R6 one per interval", ras_falls - base, 5);
    check(ord_bad == 0, "R4 strobe order", ord_bad, 0);
    check(width_bad == 0, "R5 row low width", width_bad, 0);
    check(pre_bad == 0, "R5 precharge", pre_bad, 0);
  endtask

  task automatic t_host_keeps_awake();
    int drops = 0;
    ref_gnt = 1'b0;
    for (int k = 0; k < 4; k++) begin
      host_row_act = 1'b1;
      @(negedge clk);
      host_row_act = 1'b0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (!init_done) drops++;
      end
    end
    check(drops == 0, "R11 host activity keeps done", drops, 0);
  endtask

  task automatic t_idle_wakeup();
    int n = 1001;
    int base;
    while (init_done && n < IDLE + 50) begin
      @(negedge clk);
      n++;
    end
    check(!init_done && n >= IDLE - 2 && n <= IDLE + 3, "R10 idle timeout", n, IDLE);
    base = ras_falls;
    n = 0;
    while (!init_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(init_done && ras_falls - base == WAKE, "R10 wake burst",
          ras_falls - base, WAKE);
    check(ref_req == 1'b1, "R7 request after wake", ref_req, 1);
    check(ord_bad == 0 && width_bad == 0 && pre_bad == 0, "R4 R5 shape overall",
          ord_bad + width_bad + pre_bad, 0);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_hold_without_grant();
    t_saturate_and_catchup();
    t_steady_refresh();
    t_host_keeps_awake();
    t_idle_wakeup();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule